// File: doc/BRIEF.md
# Trap Vector Target Resolver

This block works out the program-counter value a hart jumps to when it takes a trap. It receives the trap-vector register value, the cause of the trap (an interrupt flag plus an exception code), the current top-interrupt value, a select that turns on delivery through an in-memory handler table, the instruction alignment setting and the privilege of the mode that will run the handler.

The two low bits of the trap-vector value pick the mode, and the remaining bits form the base address. For direct mode, and for any synchronous exception, the target is the base itself. For an interrupt in vectored mode, the target is either the base plus four times the exception code or, when table delivery is selected, a word read from a handler table. That table is indexed by the minor interrupt identity. The table read is a single request on a small memory port that carries the handler privilege. The returned entry has its low alignment bits cleared before it becomes the target. A failed read raises a fault pulse with the address that failed, and the previous target is left untouched.

The block accepts one trap at a time. A busy output covers the whole resolution, and any trap request that arrives while busy is dropped.

Top module: `tvec_target_resolver`

## Requirements
- R1: The mode comes from `tvec_val[1:0]`: 00 is direct, 01 is vectored, and 10 or 11 behave exactly like direct. The base is `tvec_val` with bits 1:0 forced to zero.
- R2: In direct mode (including the reserved codes), the target is the base for every cause, and no memory read is started.
- R3: In vectored mode with `table_sel` low, an interrupt (`trap_is_irq`=1) resolves to base + 4 × `trap_code`.
- R4: A synchronous exception (`trap_is_irq`=0) resolves to the base in every mode and never starts a memory read.
- R5: In vectored mode with `table_sel` high, an interrupt raises `mem_req` for exactly one cycle. During that cycle `mem_addr` = base + (XLEN/8) × `topi_val[25:16]` and `mem_priv` = `handler_priv`.
- R6: A successful table entry has bit 0 cleared when `ialign_32` is 0 (16-bit alignment), and bits 1:0 cleared when `ialign_32` is 1 (32-bit alignment). All other bits pass through unchanged.
- R7: A response with `mem_rerr` high gives a one-cycle `fault` pulse with `fault_addr` equal to the table address that was read. No `tgt_valid` pulse is produced and `tgt_pc` keeps its previous value. `fault` and `tgt_valid` are never high together.
- R8: For an arithmetic target, `tgt_valid` pulses in the cycle after the accepted `trap_req`. A table target, or a fault, pulses in the cycle after the cycle in which `mem_rvalid` is sampled. A response is taken only in a cycle after the one in which `mem_req` is high.
- R9: `busy` is high from the cycle after an accepted request through the cycle of the `tgt_valid` or `fault` pulse. A `trap_req` that arrives while `busy` is high starts no read and produces no pulse.
- R10: After reset, `busy`, `tgt_valid`, `fault` and `mem_req` are low and `tgt_pc` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_req | input | 1 | One-cycle request to resolve a trap target |
| trap_is_irq | input | 1 | 1 for an interrupt, 0 for a synchronous exception |
| trap_code | input | CODE_W | Exception code of the cause |
| tvec_val | input | XLEN | Trap-vector register value (mode in bits 1:0) |
| topi_val | input | XLEN | Top-interrupt value; minor identity in bits 25:16 |
| table_sel | input | 1 | Selects in-memory table delivery for vectored interrupts |
| ialign_32 | input | 1 | 1 for 32-bit instruction alignment, 0 for 16-bit |
| handler_priv | input | 2 | Privilege of the mode that will run the handler |
| busy | output | 1 | A trap is being resolved; new requests are dropped |
| tgt_valid | output | 1 | One-cycle pulse: `tgt_pc` holds a new target |
| tgt_pc | output | XLEN | Resolved trap target |
| fault | output | 1 | One-cycle pulse: the table read failed |
| fault_addr | output | XLEN | Table address of the failed read |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | XLEN | Read address |
| mem_priv | output | 2 | Privilege to apply to the read |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | XLEN | Read data (table entry) |
| mem_rerr | input | 1 | Read response carries an error |

## Verification
The embedded assertions check, on every cycle, the protocol-shaped behaviours: `mem_req` never lasts longer than one cycle and always carries a word-aligned address, exceptions and dropped requests never start a read, an arithmetic target always arrives one cycle after acceptance, a fault never coincides with a target pulse and leaves the target unchanged, and a table target always has its alignment bits clear. The actual numbers can only be shown by the bench's scenarios, which compare them against independently computed values. These are the base and offset arithmetic, the table address for a given minor identity, the exact masked entry, the treatment of the reserved mode codes and the address reported with a fault. Response latency and busy-time requests are varied at random across many traps.

// File: rtl/tvr_pkg.sv
package tvr_pkg;

  // Mode field encoding held in the trap-vector value bits [1:0]
  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_VECT   = 2'b01,
    MODE_RSV_A  = 2'b10,
    MODE_RSV_B  = 2'b11
  } tv_mode_e;

  // How the target of an accepted trap is produced
  typedef enum logic [1:0] {
    ROUTE_BASE   = 2'd0,
    ROUTE_OFFSET = 2'd1,
    ROUTE_TABLE  = 2'd2
  } route_e;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_WAIT = 1'b1
  } fetch_state_e;

endpackage

// File: rtl/tvr_route_decode.sv
module tvr_route_decode
  import tvr_pkg::*;
(
  input  logic [1:0] mode_bits,
  input  logic       is_irq,
  input  logic       table_sel,
  output route_e     route
);

  tv_mode_e mode;
  assign mode = tv_mode_e'(mode_bits);

  // Exceptions and direct / reserved modes go to the base (R1, R2, R4)
  always_comb begin
    route = ROUTE_BASE;
    if (mode == MODE_VECT && is_irq) begin
      route = table_sel ? ROUTE_TABLE : ROUTE_OFFSET;
    end
  end

endmodule

// File: rtl/tvr_addr_calc.sv
module tvr_addr_calc #(
  parameter int XLEN      = 32,
  parameter int CODE_W    = 6,
  parameter int MINOR_LSB = 16,
  parameter int MINOR_W   = 10
) (
  input  logic [XLEN-1:0]    tvec,
  input  logic [CODE_W-1:0]  code,
  input  logic [MINOR_W-1:0] minor_id,
  output logic [XLEN-1:0]    base,
  output logic [XLEN-1:0]    offset_pc,
  output logic [XLEN-1:0]    table_addr
);

  localparam int WORD_BYTES = XLEN / 8;
  localparam int WORD_SHIFT = $clog2(WORD_BYTES);

  function automatic logic [XLEN-1:0] f_base(input logic [XLEN-1:0] v);
    return {v[XLEN-1:2], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] f_offset(input logic [XLEN-1:0] b,
                                               input logic [CODE_W-1:0] c);
    logic [XLEN-1:0] ext;
    ext = {{(XLEN-CODE_W){1'b0}}, c};
    return b + (ext << 2);
  endfunction

  function automatic logic [XLEN-1:0] f_table(input logic [XLEN-1:0] b,
                                              input logic [MINOR_W-1:0] m);
    logic [XLEN-1:0] ext;
    ext = {{(XLEN-MINOR_W){1'b0}}, m};
    return b + (ext << WORD_SHIFT);
  endfunction

  assign base       = f_base(tvec);
  assign offset_pc  = f_offset(base, code);
  assign table_addr = f_table(base, minor_id);

endmodule

// File: rtl/tvr_table_fetch.sv
module tvr_table_fetch
  import tvr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  route_e          route,
  input  logic [XLEN-1:0] arith_pc,
  input  logic [XLEN-1:0] table_addr,
  input  logic            ialign_32,
  input  logic [1:0]      handler_priv,
  output logic            busy,
  output logic            tgt_valid,
  output logic [XLEN-1:0] tgt_pc,
  output logic            fault,
  output logic [XLEN-1:0] fault_addr,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  output logic [1:0]      mem_priv,
  input  logic            mem_rvalid,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_rerr
);

  fetch_state_e    state;
  logic            req_q;
  logic [XLEN-1:0] addr_q;
  logic [1:0]      priv_q;
  logic            ia32_q;
  logic [XLEN-1:0] pc_q;
  logic            valid_q;
  logic            fault_q;
  logic [XLEN-1:0] faddr_q;

  // Named events for the assertions
  logic            start_table;
  logic            start_arith;
  logic            resp_take;
  logic            resp_ok;
  logic            resp_bad;
  logic [XLEN-1:0] entry_masked;

  function automatic logic [XLEN-1:0] f_mask(input logic [XLEN-1:0] d,
                                             input logic wide);
    return {d[XLEN-1:2], d[1] & ~wide, 1'b0};
  endfunction

  assign start_table  = accept && (route == ROUTE_TABLE);
  assign start_arith  = accept && (route != ROUTE_TABLE);
  assign resp_take    = (state == FS_WAIT) && mem_rvalid && !req_q;
  assign resp_ok      = resp_take && !mem_rerr;
  assign resp_bad     = resp_take && mem_rerr;
  assign entry_masked = f_mask(mem_rdata, ia32_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= FS_IDLE;
      req_q   <= 1'b0;
      addr_q  <= '0;
      priv_q  <= '0;
      ia32_q  <= 1'b0;
      pc_q    <= '0;
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      faddr_q <= '0;
    end else begin
      req_q   <= 1'b0;
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      if (start_table) begin
        state  <= FS_WAIT;
        req_q  <= 1'b1;
        addr_q <= table_addr;
        priv_q <= handler_priv;
        ia32_q <= ialign_32;
      end else if (start_arith) begin
        pc_q    <= arith_pc;
        valid_q <= 1'b1;
      end
      if (resp_ok) begin
        state   <= FS_IDLE;
        pc_q    <= entry_masked;
        valid_q <= 1'b1;
      end else if (resp_bad) begin
        state   <= FS_IDLE;
        fault_q <= 1'b1;
        faddr_q <= addr_q;
      end
    end
  end

  assign busy       = (state == FS_WAIT) || valid_q || fault_q;
  assign tgt_valid  = valid_q;
  assign tgt_pc     = pc_q;
  assign fault      = fault_q;
  assign fault_addr = faddr_q;
  assign mem_req    = req_q;
  assign mem_addr   = addr_q;
  assign mem_priv   = priv_q;

  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R5
  AST_REQ_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R5
  AST_TABLE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ok |=> (tgt_valid && !tgt_pc[0] && (!ia32_q || !tgt_pc[1]))); // R6
  AST_FAULT_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    resp_bad |=> (fault && !tgt_valid && $stable(tgt_pc))); // R7
  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tgt_valid && fault)); // R7
  AST_TABLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    resp_take |=> (tgt_valid || fault)); // R8

endmodule

// File: rtl/tvec_target_resolver.sv
module tvec_target_resolver
  import tvr_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CODE_W    = 6,
  parameter int MINOR_LSB = 16,
  parameter int MINOR_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  input  logic              trap_is_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   tvec_val,
  input  logic [XLEN-1:0]   topi_val,
  input  logic              table_sel,
  input  logic              ialign_32,
  input  logic [1:0]        handler_priv,
  output logic              busy,
  output logic              tgt_valid,
  output logic [XLEN-1:0]   tgt_pc,
  output logic              fault,
  output logic [XLEN-1:0]   fault_addr,
  output logic              mem_req,
  output logic [XLEN-1:0]   mem_addr,
  output logic [1:0]        mem_priv,
  input  logic              mem_rvalid,
  input  logic [XLEN-1:0]   mem_rdata,
  input  logic              mem_rerr
);

  localparam int MINOR_MSB = MINOR_LSB + MINOR_W - 1;

  route_e             route;
  logic [XLEN-1:0]    base;
  logic [XLEN-1:0]    offset_pc;
  logic [XLEN-1:0]    table_addr;
  logic [XLEN-1:0]    arith_pc;
  logic [MINOR_W-1:0] minor_id;
  logic               accept;
  logic               unused_topi;

  assign minor_id    = topi_val[MINOR_MSB:MINOR_LSB];
  assign unused_topi = ^{topi_val[XLEN-1:MINOR_MSB+1], topi_val[MINOR_LSB-1:0]};
  assign accept      = trap_req && !busy;
  assign arith_pc    = (route == ROUTE_OFFSET) ? offset_pc : base;

  tvr_route_decode u_decode (
    .mode_bits (tvec_val[1:0]),
    .is_irq    (trap_is_irq),
    .table_sel (table_sel),
    .route     (route)
  );

  tvr_addr_calc #(
    .XLEN      (XLEN),
    .CODE_W    (CODE_W),
    .MINOR_LSB (MINOR_LSB),
    .MINOR_W   (MINOR_W)
  ) u_addr (
    .tvec       (tvec_val),
    .code       (trap_code),
    .minor_id   (minor_id),
    .base       (base),
    .offset_pc  (offset_pc),
    .table_addr (table_addr)
  );

  tvr_table_fetch #(.XLEN(XLEN)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .route        (route),
    .arith_pc     (arith_pc),
    .table_addr   (table_addr),
    .ialign_32    (ialign_32),
    .handler_priv (handler_priv),
    .busy         (busy),
    .tgt_valid    (tgt_valid),
    .tgt_pc       (tgt_pc),
    .fault        (fault),
    .fault_addr   (fault_addr),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_priv     (mem_priv),
    .mem_rvalid   (mem_rvalid),
    .mem_rdata    (mem_rdata),
    .mem_rerr     (mem_rerr)
  );

  AST_ARITH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && route != ROUTE_TABLE) |=> (tgt_valid && !mem_req)); // R8
  AST_EXCEPTION_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !trap_is_irq) |=> !mem_req); // R4
  AST_DIRECT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tvec_val[1:0] != 2'b01) |=> !mem_req); // R2
  AST_BUSY_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && busy) |=> !mem_req); // R9
  AST_TABLE_READ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && route == ROUTE_TABLE) |=> (mem_req && busy && mem_priv == $past(handler_priv))); // R5

endmodule

// File: tb/tvec_target_resolver_tb.sv
`timescale 1ns/1ps
module tvec_target_resolver_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_req = 1'b0;
  logic        trap_is_irq = 1'b0;
  logic [5:0]  trap_code = '0;
  logic [31:0] tvec_val = '0;
  logic [31:0] topi_val = '0;
  logic        table_sel = 1'b0;
  logic        ialign_32 = 1'b0;
  logic [1:0]  handler_priv = '0;
  logic        busy, tgt_valid, fault, mem_req;
  logic [31:0] tgt_pc, fault_addr, mem_addr;
  logic [1:0]  mem_priv;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_rerr = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_pc = '0;

  always #2.5 clk = ~clk;

  tvec_target_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_is_irq(trap_is_irq),
    .trap_code(trap_code), .tvec_val(tvec_val), .topi_val(topi_val),
    .table_sel(table_sel), .ialign_32(ialign_32), .handler_priv(handler_priv),
    .busy(busy), .tgt_valid(tgt_valid), .tgt_pc(tgt_pc), .fault(fault),
    .fault_addr(fault_addr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_priv(mem_priv), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_rerr(mem_rerr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference arithmetic, written independently of the design
  function automatic logic [31:0] ref_base(input logic [31:0] t);
    return t & 32'hFFFF_FFFC;
  endfunction
  function automatic bit ref_uses_table(input logic [31:0] t, input logic irq, input logic ts);
    return (t[1:0] == 2'b01) && irq && ts;
  endfunction
  function automatic logic [31:0] ref_arith(input logic [31:0] t, input logic irq, input logic [5:0] c);
    if (t[1:0] == 2'b01 && irq) return ref_base(t) + 32'(c) * 4;
    return ref_base(t);
  endfunction
  function automatic logic [31:0] ref_taddr(input logic [31:0] t, input logic [31:0] tp);
    return ref_base(t) + ((tp >> 16) & 32'h3FF) * 4;
  endfunction
  function automatic logic [31:0] ref_mask(input logic [31:0] d, input logic w);
    return w ? (d & 32'hFFFF_FFFC) : (d & 32'hFFFF_FFFE);
  endfunction

  task automatic do_trap(input logic [31:0] tv, input logic irq, input logic [5:0] code,
                         input logic [31:0] tp, input logic ts, input logic w,
                         input logic [1:0] pv, input logic err, input int lat_in,
                         input logic poke, input logic [31:0] rd);
    int lat;
    logic [31:0] exp_pc;
    lat = (poke && lat_in < 2) ? 2 : lat_in;
    @(negedge clk);
    tvec_val = tv; trap_is_irq = irq; trap_code = code; topi_val = tp;
    table_sel = ts; ialign_32 = w; handler_priv = pv; trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0;
    if (!ref_uses_table(tv, irq, ts)) begin
      exp_pc = ref_arith(tv, irq, code);
      check("R1/R2/R3/R4 target", tgt_pc, exp_pc);
      check("R8 arith pulse", 32'(tgt_valid), 32'd1);
      check("R4/R2 no read", 32'(mem_req), 32'd0);
      check("R9 busy in pulse", 32'(busy), 32'd1);
      last_pc = exp_pc;
      if (poke) begin
        tvec_val = 32'h0000_1001; trap_is_irq = 1'b1; table_sel = 1'b1; trap_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
        check("R9 dropped req no read", 32'(mem_req), 32'd0);
        check("R9 dropped req no pulse", 32'(tgt_valid), 32'd0);
      end else begin
        @(negedge clk);
        check("R9 busy clears", 32'(busy), 32'd0);
      end
    end else begin
      check("R5 mem_req", 32'(mem_req), 32'd1);
      check("R5 mem_addr", mem_addr, ref_taddr(tv, tp));
      check("R5 mem_priv", 32'(mem_priv), 32'(pv));
      check("R8 no early pulse", 32'(tgt_valid | fault), 32'd0);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        if (i == 0) check("R5 single-cycle req", 32'(mem_req), 32'd0);
        if (i == 1 && poke) begin
          trap_req = 1'b0;
          check("R9 dropped req no read", 32'(mem_req), 32'd0);
          check("R9 busy while waiting", 32'(busy), 32'd1);
        end
        if (i == 0 && poke) begin
          tvec_val = 32'h0000_2000; trap_is_irq = 1'b0; trap_req = 1'b1;
        end
      end
      mem_rvalid = 1'b1; mem_rdata = rd; mem_rerr = err;
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rerr = 1'b0; mem_rdata = 32'hDEAD_BEEF;
      if (err) begin
        check("R7 fault pulse", 32'(fault), 32'd1);
        check("R7 no target pulse", 32'(tgt_valid), 32'd0);
        check("R7 fault addr", fault_addr, ref_taddr(tv, tp));
        check("R7 target kept", tgt_pc, last_pc);
      end else begin
        exp_pc = ref_mask(rd, w);
        check("R8 table pulse", 32'(tgt_valid), 32'd1);
        check("R6 masked entry", tgt_pc, exp_pc);
        check("R7 no fault", 32'(fault), 32'd0);
        last_pc = exp_pc;
      end
      check("R9 busy in pulse", 32'(busy), 32'd1);
      @(negedge clk);
      check("R9 busy clears", 32'(busy), 32'd0);
      check("R8 single pulse", 32'(tgt_valid | fault), 32'd0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R10 busy", 32'(busy), 32'd0);
    check("R10 tgt_valid", 32'(tgt_valid), 32'd0);
    check("R10 fault", 32'(fault), 32'd0);
    check("R10 mem_req", 32'(mem_req), 32'd0);
    check("R10 tgt_pc", tgt_pc, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corner cases
    do_trap(32'h8000_0103, 1'b0, 6'd2,  32'h0, 1'b0, 1'b0, 2'd3, 1'b0, 1, 1'b0, 0); // R2 R4
    do_trap(32'h8000_0100, 1'b1, 6'd7,  32'h0, 1'b1, 1'b0, 2'd3, 1'b0, 1, 1'b0, 0); // R2
    do_trap(32'h4000_0202, 1'b1, 6'd9,  32'h0005_0000, 1'b1, 1'b0, 2'd1, 1'b0, 1, 1'b0, 0); // R1 reserved 10
    do_trap(32'h4000_0303, 1'b1, 6'd9,  32'h0005_0000, 1'b1, 1'b0, 2'd1, 1'b0, 1, 1'b0, 0); // R1 reserved 11
    do_trap(32'h0000_1001, 1'b1, 6'd11, 32'h0, 1'b0, 1'b0, 2'd3, 1'b0, 1, 1'b0, 0); // R3
    do_trap(32'h0000_1001, 1'b1, 6'd63, 32'h0, 1'b0, 1'b0, 2'd3, 1'b0, 1, 1'b0, 0); // R3 max code
    do_trap(32'h0000_1001, 1'b0, 6'd5,  32'h0, 1'b1, 1'b0, 2'd3, 1'b0, 1, 1'b0, 0); // R4 vectored exception
    do_trap(32'h0010_0001, 1'b1, 6'd11, 32'h03FF_0000, 1'b1, 1'b1, 2'd3, 1'b0, 1, 1'b0, 32'h1234_5677); // R5 R6 w32
    do_trap(32'h0010_0001, 1'b1, 6'd11, 32'h0001_00FF, 1'b1, 1'b0, 2'd1, 1'b0, 3, 1'b0, 32'h8765_4323); // R6 w16
    do_trap(32'h0020_0001, 1'b1, 6'd11, 32'h0007_0000, 1'b1, 1'b1, 2'd1, 1'b1, 2, 1'b0, 32'hFFFF_FFFF); // R7
    do_trap(32'h0020_0001, 1'b1, 6'd11, 32'h0002_0000, 1'b1, 1'b1, 2'd3, 1'b0, 4, 1'b1, 32'hAAAA_5555); // R9 wait
    do_trap(32'h0000_3000, 1'b1, 6'd1,  32'h0, 1'b0, 1'b0, 2'd3, 1'b0, 1, 1'b1, 0); // R9 pulse cycle

    // Constrained random traps
    for (int n = 0; n < 400; n++) begin
      logic [31:0] tv;
      tv = $urandom;
      if ($urandom_range(0, 2) != 0) tv[1:0] = 2'b01;
      do_trap(tv, 1'($urandom), 6'($urandom), $urandom, 1'($urandom), 1'($urandom),
              2'($urandom), ($urandom_range(0, 4) == 0), $urandom_range(1, 5),
              ($urandom_range(0, 5) == 0), $urandom);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule